// File: doc/BRIEF.md
# Scanline Table-Driven DMA Sequencer

This block is one channel of a line-synchronous DMA engine. A frame-start pulse makes it walk a table in memory. It copies the table start address into a running table pointer and fetches the first header byte. In indirect mode it also fetches a 16-bit data pointer. After that, every line-start pulse makes the channel move a small group of bytes, one, two or four according to the transfer mode, between memory and a group of peripheral port addresses. The header then counts down.

Each header byte holds a 7-bit line count in bits 6:0 and a repeat flag in bit 7. When the repeat flag is set, the channel transfers on every line of the entry. When it is clear, the channel transfers only on the first line of the entry. When the count runs out, the next table byte becomes the new header. A new header of zero stops the channel until the next frame-start pulse. The byte movement is done by an external bus stub: the block only issues table fetch requests (`rd_req`, data returned in the same cycle) and one-byte transfer requests (`xfer_req`) that carry the memory address, the port address and the direction.

Top module: `lsq_line_dma`

## Requirements
- R1: On `frame_init` with `chan_en` high, the channel loads `table_addr` into its table pointer and fetches one header byte from `{table_bank, pointer}`. The pointer then advances by one. A fetched header of 0x00 raises `finished`.
- R2: In indirect mode (`ind_mode`=1), the header fetch is followed by two more table fetches: first the low byte of the data pointer, then the high byte. Each fetch advances the table pointer.
- R3: `frame_init` clears `finished` and the pending-transfer state whatever `chan_en` is. While `chan_en` is low, `line_start` produces no request.
- R4: A line transfer issues 1, 2, 2, 4, 4, 4, 2 or 4 consecutive byte requests for `mode` 0 to 7. For byte k, the port offset from `port_base` follows this pattern: modes 0/2/6 give 0; modes 1/5 give k[0]; modes 3/7 give k[1]; mode 4 gives k. The port sum wraps in 8 bits.
- R5: In direct mode, the transfer address is `{table_bank, table pointer}`. In indirect mode it is `{ind_bank, data pointer}`. The pointer in use increments after every byte.
- R6: After each line where the channel is not finished, the header is decremented and its new bit 7 decides whether the next line transfers. One table byte is always fetched. If the decremented count (bits 6:0) is nonzero, that byte is discarded and the table pointer does not move.
- R7: When the decremented count is zero, the fetched byte becomes the new header, the table pointer advances, and the next line transfers.
- R8: When a new header is loaded in indirect mode, two pointer bytes follow, low then high. If the new header is 0x00 and `last_active` is high, only one byte is fetched. It becomes the high byte, and the low byte is forced to 0x00.
- R9: A header of 0x00 sets `finished`. Afterwards `line_start` causes no request until the next `frame_init`, which restarts the channel.
- R10: Every table fetch holds `rd_req` for FETCH_CYCLES consecutive clocks, with the address steady. A `line_start` that arrives while a line or fetch is in progress is ignored.
- R11: `xfer_to_mem` follows the `to_mem` direction control on every transfer request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_init | input | 1 | Frame-start pulse: restart the table walk |
| line_start | input | 1 | Line-start pulse: run one line |
| chan_en | input | 1 | Channel enable |
| mode | input | 3 | Transfer mode (byte count and port pattern) |
| ind_mode | input | 1 | 1 = data comes through an indirect pointer |
| to_mem | input | 1 | Direction: 1 = port to memory, 0 = memory to port |
| port_base | input | PORT_W | Base port address |
| table_addr | input | ADDR_W | Table start address |
| table_bank | input | BANK_W | Bank of the table (and of direct data) |
| ind_bank | input | BANK_W | Bank of indirect data |
| last_active | input | 1 | No higher-numbered channel is still running |
| rd_data | input | 8 | Table byte returned by the stub in the `rd_req` cycle |
| rd_req | output | 1 | Table fetch request |
| rd_addr | output | BANK_W+ADDR_W | Table fetch address |
| xfer_req | output | 1 | One-byte transfer request |
| xfer_addr | output | BANK_W+ADDR_W | Memory side address of the transfer |
| xfer_port | output | PORT_W | Port side address of the transfer |
| xfer_to_mem | output | 1 | Transfer direction |
| finished | output | 1 | Channel terminated for this frame |

## Verification
A corrupted header, table pointer or data pointer does not stay hidden for long. It shows up in the address of the next fetch, or on a later line it shows up as a byte count that is too short or too long. At the latest it appears once the header reaches zero, because `finished` then rises on the wrong line. The bench compares every request cycle of every line against a transaction model, so it sees such faults at their first visible request. Errors in the skip and repeat logic show up as whole lines with missing or extra transfers. Errors in the indirect shortcut show up as one pointer fetch too many or too few on the terminating line.

// File: rtl/lsq_pkg.sv
package lsq_pkg;
    localparam int HDR_W      = 8;
    localparam int REPEAT_BIT = 7;
    localparam int MODE_W     = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_PLO,
        ST_PHI,
        ST_XFER,
        ST_NEXT
    } lsq_state_e;
endpackage

// File: rtl/lsq_mode_decode.sv
module lsq_mode_decode
    import lsq_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    input  logic [1:0]        idx,
    output logic [1:0]        offset,
    output logic              last
);
    logic [2:0] nbytes;

    always_comb begin
        case (mode)
            3'd0:                nbytes = 3'd1;
            3'd1, 3'd2, 3'd6:    nbytes = 3'd2;
            default:             nbytes = 3'd4;
        endcase
        case (mode)
            3'd1, 3'd5: offset = {1'b0, idx[0]};
            3'd3, 3'd7: offset = {1'b0, idx[1]};
            3'd4:       offset = idx;
            default:    offset = 2'd0;
        endcase
        last = ({1'b0, idx} == nbytes - 3'd1);
    end
endmodule

// File: rtl/lsq_fetch_timer.sv
module lsq_fetch_timer #(
    parameter int CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic active,
    output logic done
);
    localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        done  = active && (cnt_q == CW'(CYCLES - 1));
        cnt_d = (clear || !active || done) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assert_done_needs_active_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (cnt_q == '0));
endmodule

// File: rtl/lsq_line_dma.sv
module lsq_line_dma
    import lsq_pkg::*;
#(
    parameter int ADDR_W       = 16,
    parameter int BANK_W       = 8,
    parameter int PORT_W       = 8,
    parameter int FETCH_CYCLES = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     frame_init,
    input  logic                     line_start,
    input  logic                     chan_en,
    input  logic [MODE_W-1:0]        mode,
    input  logic                     ind_mode,
    input  logic                     to_mem,
    input  logic [PORT_W-1:0]        port_base,
    input  logic [ADDR_W-1:0]        table_addr,
    input  logic [BANK_W-1:0]        table_bank,
    input  logic [BANK_W-1:0]        ind_bank,
    input  logic                     last_active,
    input  logic [7:0]               rd_data,
    output logic                     rd_req,
    output logic [BANK_W+ADDR_W-1:0] rd_addr,
    output logic                     xfer_req,
    output logic [BANK_W+ADDR_W-1:0] xfer_addr,
    output logic [PORT_W-1:0]        xfer_port,
    output logic                     xfer_to_mem,
    output logic                     finished
);
    localparam int FA_W = BANK_W + ADDR_W;

    typedef struct packed {
        lsq_state_e        state;
        logic [ADDR_W-1:0] tbl_ptr;
        logic [ADDR_W-1:0] ind_ptr;
        logic [HDR_W-1:0]  hdr;
        logic              do_xfer;
        logic              finished;
        logic [1:0]        idx;
    } regs_t;

    regs_t r_d, r_q;

    logic       fetching, fetch_done, byte_last;
    logic [1:0] port_off;
    logic [HDR_W-1:0] hdr_dec;

    lsq_mode_decode u_decode (
        .mode   (mode),
        .idx    (r_q.idx),
        .offset (port_off),
        .last   (byte_last)
    );

    lsq_fetch_timer #(.CYCLES(FETCH_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (frame_init),
        .active (fetching),
        .done   (fetch_done)
    );

    always_comb begin
        fetching = (r_q.state == ST_HDR) || (r_q.state == ST_PLO) ||
                   (r_q.state == ST_PHI) || (r_q.state == ST_NEXT);
        hdr_dec  = r_q.hdr - 1'b1;
        r_d      = r_q;

        case (r_q.state)
            ST_IDLE: begin
                if (line_start && chan_en && !r_q.finished) begin
                    if (r_q.do_xfer) begin
                        r_d.state = ST_XFER;
                        r_d.idx   = 2'd0;
                    end else begin
                        r_d.hdr     = hdr_dec;
                        r_d.do_xfer = hdr_dec[REPEAT_BIT];
                        r_d.state   = ST_NEXT;
                    end
                end
            end
            ST_HDR: begin
                if (fetch_done) begin
                    r_d.hdr      = rd_data;
                    r_d.tbl_ptr  = r_q.tbl_ptr + 1'b1;
                    r_d.finished = (rd_data == '0);
                    r_d.state    = ind_mode ? ST_PLO : ST_IDLE;
                end
            end
            ST_PLO: begin
                if (fetch_done) begin
                    r_d.ind_ptr[7:0] = rd_data;
                    r_d.tbl_ptr      = r_q.tbl_ptr + 1'b1;
                    r_d.state        = ST_PHI;
                end
            end
            ST_PHI: begin
                if (fetch_done) begin
                    r_d.ind_ptr[ADDR_W-1:8] = rd_data[ADDR_W-9:0];
                    r_d.tbl_ptr             = r_q.tbl_ptr + 1'b1;
                    r_d.state               = ST_IDLE;
                end
            end
            ST_XFER: begin
                if (ind_mode) r_d.ind_ptr = r_q.ind_ptr + 1'b1;
                else          r_d.tbl_ptr = r_q.tbl_ptr + 1'b1;
                if (byte_last) begin
                    r_d.hdr     = hdr_dec;
                    r_d.do_xfer = hdr_dec[REPEAT_BIT];
                    r_d.state   = ST_NEXT;
                end else begin
                    r_d.idx = r_q.idx + 1'b1;
                end
            end
            ST_NEXT: begin
                if (fetch_done) begin
                    r_d.state = ST_IDLE;
                    if (r_q.hdr[REPEAT_BIT-1:0] == '0) begin
                        r_d.hdr      = rd_data;
                        r_d.tbl_ptr  = r_q.tbl_ptr + 1'b1;
                        r_d.do_xfer  = 1'b1;
                        r_d.finished = (rd_data == '0);
                        if (ind_mode) begin
                            if (rd_data == '0 && last_active) begin
                                r_d.ind_ptr[7:0] = 8'h00;
                                r_d.state        = ST_PHI;
                            end else begin
                                r_d.state = ST_PLO;
                            end
                        end
                    end
                end
            end
            default: r_d.state = ST_IDLE;
        endcase

        if (frame_init) begin
            r_d.finished = 1'b0;
            r_d.do_xfer  = chan_en;
            r_d.idx      = 2'd0;
            if (chan_en) begin
                r_d.tbl_ptr = table_addr;
                r_d.state   = ST_HDR;
            end else begin
                r_d.state = ST_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state    <= ST_IDLE;
            r_q.tbl_ptr  <= '0;
            r_q.ind_ptr  <= '0;
            r_q.hdr      <= '0;
            r_q.do_xfer  <= 1'b0;
            r_q.finished <= 1'b0;
            r_q.idx      <= 2'd0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_req      = fetching;
    assign rd_addr     = {table_bank, r_q.tbl_ptr};
    assign xfer_req    = (r_q.state == ST_XFER);
    assign xfer_addr   = ind_mode ? {ind_bank, r_q.ind_ptr} : {table_bank, r_q.tbl_ptr};
    assign xfer_port   = port_base + PORT_W'(port_off);
    assign xfer_to_mem = to_mem;
    assign finished    = r_q.finished;

    // Length of each run of rd_req, for the fetch-duration check
    logic [15:0] run_d, run_q;
    always_comb run_d = frame_init ? '0 : (rd_req ? run_q + 1'b1 : '0);
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= run_d;
    end

    assert_fetch_whole_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_req && run_q != '0) |-> (run_q % FETCH_CYCLES == 0));

    assert_fetch_addr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && $past(rd_req) && !$past(frame_init) && run_q % FETCH_CYCLES != 0)
        |-> (rd_addr == $past(rd_addr)));

    assert_xfer_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && $past(xfer_req) && $stable(ind_mode) && $stable(table_bank) && $stable(ind_bank))
        |-> (xfer_addr[ADDR_W-1:0] == ADDR_W'($past(xfer_addr[ADDR_W-1:0]) + 1'b1)));

    assert_port_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req |-> (PORT_W'(xfer_port - port_base) < PORT_W'(4)));

    assert_init_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_init |=> !finished);

    assert_quiet_when_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (finished && !rd_req && !frame_init) |=> (!rd_req && !xfer_req));

    assert_no_req_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!chan_en && !rd_req && !xfer_req && !frame_init && $stable(chan_en)) |=> !xfer_req);
endmodule

// File: tb/tb_lsq_line_dma.sv
module tb_lsq_line_dma;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_init = 1'b0, line_start = 1'b0, chan_en = 1'b0;
    logic [2:0]  mode = '0;
    logic        ind_mode = 1'b0, to_mem = 1'b0, last_active = 1'b0;
    logic [7:0]  port_base = '0, table_bank = 8'h12, ind_bank = 8'h34;
    logic [15:0] table_addr = 16'h0100;
    logic [7:0]  rd_data;
    logic        rd_req, xfer_req, xfer_to_mem, finished;
    logic [23:0] rd_addr, xfer_addr;
    logic [7:0]  xfer_port;

    always #4 clk = ~clk;

    logic [7:0] mem [0:1023];
    assign rd_data = mem[rd_addr[9:0]];

    lsq_line_dma dut (
        .clk(clk), .rst_n(rst_n), .frame_init(frame_init), .line_start(line_start),
        .chan_en(chan_en), .mode(mode), .ind_mode(ind_mode), .to_mem(to_mem),
        .port_base(port_base), .table_addr(table_addr), .table_bank(table_bank),
        .ind_bank(ind_bank), .last_active(last_active), .rd_data(rd_data),
        .rd_req(rd_req), .rd_addr(rd_addr), .xfer_req(xfer_req), .xfer_addr(xfer_addr),
        .xfer_port(xfer_port), .xfer_to_mem(xfer_to_mem), .finished(finished)
    );

    int errs = 0, checks = 0;

    // observed and expected request streams (kind 1 = fetch, 2 = transfer)
    int         a_n = 0, e_n = 0;
    int         a_k [0:127];
    logic [23:0] a_a [0:127];
    logic [7:0]  a_p [0:127];
    logic        a_d [0:127];
    int         e_k [0:127];
    logic [23:0] e_a [0:127];
    logic [7:0]  e_p [0:127];
    logic        e_d [0:127];

    always @(negedge clk) begin
        if (a_n < 128) begin
            if (rd_req) begin
                a_k[a_n] = 1; a_a[a_n] = rd_addr; a_p[a_n] = 8'h00; a_d[a_n] = 1'b0; a_n++;
            end else if (xfer_req) begin
                a_k[a_n] = 2; a_a[a_n] = xfer_addr; a_p[a_n] = xfer_port; a_d[a_n] = xfer_to_mem; a_n++;
            end
        end
    end

    // bench-side transaction model state
    logic [15:0] m_tptr, m_iptr;
    logic [7:0]  m_hdr;
    logic        m_doxf, m_fin;

    function automatic int nbytes(input logic [2:0] m);
        case (m)
            3'd0: return 1;
            3'd1, 3'd2, 3'd6: return 2;
            default: return 4;
        endcase
    endfunction

    function automatic logic [7:0] poff(input logic [2:0] m, input int k);
        case (m)
            3'd1, 3'd5: return 8'(k % 2);
            3'd3, 3'd7: return 8'(k / 2);
            3'd4: return 8'(k);
            default: return 8'd0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic push_e(input int k, input logic [23:0] a, input logic [7:0] p, input logic d);
        if (e_n < 128) begin
            e_k[e_n] = k; e_a[e_n] = a; e_p[e_n] = p; e_d[e_n] = d; e_n++;
        end
    endtask

    task automatic push_fetch(input logic [15:0] p);
        for (int c = 0; c < 4; c++) push_e(1, {table_bank, p}, 8'h00, 1'b0);  // R10: 4 cycles
    endtask

    task automatic compare(input string req);
        chk(a_n == e_n, req, "request cycle count", a_n, e_n);
        for (int i = 0; i < e_n && i < a_n; i++) begin
            chk(a_k[i] == e_k[i], req, $sformatf("kind[%0d]", i), a_k[i], e_k[i]);
            chk(a_a[i] == e_a[i], (e_k[i] == 2) ? "R5" : req, $sformatf("addr[%0d]", i), a_a[i], e_a[i]);
            if (e_k[i] == 2) begin
                chk(a_p[i] == e_p[i], "R4", $sformatf("port[%0d]", i), a_p[i], e_p[i]);
                chk(a_d[i] == e_d[i], "R11", $sformatf("dir[%0d]", i), a_d[i], e_d[i]);
            end
        end
    endtask

    task automatic pulse_init;
        a_n = 0; e_n = 0;
        @(posedge clk); #1 frame_init = 1'b1;
        @(posedge clk); #1 frame_init = 1'b0;
        repeat (40) @(posedge clk);
        #1;
    endtask

    task automatic pulse_line;
        a_n = 0; e_n = 0;
        @(posedge clk); #1 line_start = 1'b1;
        @(posedge clk); #1 line_start = 1'b0;
        @(posedge clk); #1 line_start = 1'b1;   // R10: arrives mid-line, ignored
        @(posedge clk); #1 line_start = 1'b0;
        repeat (60) @(posedge clk);
        #1;
    endtask

    task automatic model_init;
        m_fin = 1'b0; m_doxf = chan_en;
        if (!chan_en) return;
        m_tptr = table_addr;
        push_fetch(m_tptr);
        m_hdr = mem[m_tptr[9:0]]; m_tptr++;
        m_fin = (m_hdr == 8'h00);
        if (ind_mode) begin
            push_fetch(m_tptr); m_iptr[7:0]  = mem[m_tptr[9:0]]; m_tptr++;
            push_fetch(m_tptr); m_iptr[15:8] = mem[m_tptr[9:0]]; m_tptr++;
        end
    endtask

    task automatic model_line;
        logic [7:0] nb;
        if (!chan_en || m_fin) return;
        if (m_doxf) begin
            for (int k = 0; k < nbytes(mode); k++) begin
                if (ind_mode) begin push_e(2, {ind_bank, m_iptr}, port_base + poff(mode, k), to_mem); m_iptr++; end
                else          begin push_e(2, {table_bank, m_tptr}, port_base + poff(mode, k), to_mem); m_tptr++; end
            end
        end
        m_hdr--; m_doxf = m_hdr[7];
        push_fetch(m_tptr); nb = mem[m_tptr[9:0]];
        if (m_hdr[6:0] == 7'd0) begin
            m_hdr = nb; m_tptr++; m_doxf = 1'b1; m_fin = (nb == 8'h00);
            if (ind_mode) begin
                if (nb == 8'h00 && last_active) begin
                    push_fetch(m_tptr); m_iptr = {mem[m_tptr[9:0]], 8'h00}; m_tptr++;
                end else begin
                    push_fetch(m_tptr); m_iptr[7:0]  = mem[m_tptr[9:0]]; m_tptr++;
                    push_fetch(m_tptr); m_iptr[15:8] = mem[m_tptr[9:0]]; m_tptr++;
                end
            end
        end
    endtask

    task automatic build_table(input bit zero_first);
        logic [7:0] hl [0:4];
        int pos;
        hl[0] = 8'h03; hl[1] = 8'h82; hl[2] = 8'h01; hl[3] = 8'h81; hl[4] = 8'h00;
        for (int i = 0; i < 1024; i++) mem[i] = 8'(i * 7 + 3);
        pos = 16'h0100;
        if (zero_first) begin mem[pos] = 8'h00; return; end
        for (int i = 0; i < 5; i++) begin
            mem[pos] = hl[i]; pos++;
            if (ind_mode) pos += 2;
            else if (hl[i] != 8'h00) pos += (hl[i][7] ? int'(hl[i][6:0]) : 1) * nbytes(mode);
        end
    endtask

    task automatic run_frame(input string tag);
        int lines;
        pulse_init; model_init;
        compare(ind_mode ? "R2" : "R1");
        chk(finished == m_fin, "R1", {tag, " finished after init"}, finished, m_fin);
        lines = 0;
        while (!m_fin && lines < 40) begin
            pulse_line; model_line;
            compare(ind_mode ? "R8" : "R6");
            chk(finished == m_fin, "R7", {tag, " finished after line"}, finished, m_fin);
            lines++;
        end
        for (int x = 0; x < 2; x++) begin
            pulse_line; model_line;
            chk(a_n == 0, "R9", {tag, " request after termination"}, a_n, 0);
            chk(finished == 1'b1, "R9", {tag, " finished held"}, finished, 1);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(finished == 1'b0, "R3", "reset finished", finished, 0);
        chk(rd_req == 1'b0, "R10", "reset rd_req", rd_req, 0);
        chk(xfer_req == 1'b0, "R4", "reset xfer_req", xfer_req, 0);

        chan_en = 1'b1;
        for (int m = 0; m < 8; m++) begin
            for (int ind = 0; ind < 2; ind++) begin
                for (int la = 0; la < 2; la++) begin
                    mode = 3'(m); ind_mode = ind[0]; last_active = la[0];
                    to_mem = mode[0] ^ ind_mode;
                    port_base = 8'h20 + 8'(m * 8'h1F);
                    build_table(1'b0);
                    run_frame($sformatf("m%0d i%0d l%0d", m, ind, la));
                end
            end
        end

        // R1 header of zero at init, indirect still loads its pointer
        mode = 3'd4; ind_mode = 1'b1; last_active = 1'b1;
        build_table(1'b1);
        run_frame("zero-first");

        // R3 frame init with channel disabled clears finished; lines do nothing
        chan_en = 1'b0;
        pulse_init;
        chk(a_n == 0, "R3", "disabled init requests", a_n, 0);
        chk(finished == 1'b0, "R3", "disabled init clears finished", finished, 0);
        pulse_line;
        chk(a_n == 0, "R3", "disabled line requests", a_n, 0);

        // R9 channel restarts on the next frame
        chan_en = 1'b1; mode = 3'd1; ind_mode = 1'b0; last_active = 1'b0;
        build_table(1'b0);
        run_frame("restart");

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog: run did not complete actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule